// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog

The block keeps a free-running timebase counter that advances on every cycle where a tick-enable input is high. A 6-bit period value chooses one bit of that counter to watch. Each time the chosen bit goes from 0 to 1, a timeout event occurs. The lower the period value, the higher the bit that is watched, and so the longer the interval between events. A period of 0 watches the most significant bit, which in practice switches the watchdog off.

Software services the watchdog by writing ones to the two escalation flags. If events arrive without service, they escalate through three stages:
- The first event only sets a "next-armed" flag.
- The second event sets an interrupt flag. This flag drives the interrupt output when interrupt enable is on.
- The third event fires a one-cycle reset request, if the reset-control field holds a nonzero value.

The reset-control field cannot be changed once it holds a nonzero value, until the block itself is reset.

Registers are written through a single-cycle write strobe with a one-bit select: 0 selects the control register and 1 selects the status register. Both registers are always visible on read ports. The timebase value is also visible on its own port.

Top module: `esc_wdog`

## Requirements
- R1: After reset, the timebase, the control register and the status register are all zero, and `irq` and `rst_req` are low.
- R2: `tb_value` increases by exactly one after each cycle in which `tick_en` is high, and holds its value otherwise.
- R3: The period field is split across the control register. Its low two bits sit at control[31:30] and its high four bits at control[20:17]. A period p watches timebase bit 63-p. A 0-to-1 change of that bit is a timeout event, and the status register reflects the event one cycle after `tb_value` shows the change. Period 0 watches bit 63.
- R4: An event while the next-armed flag (status[31]) is clear sets only that flag.
- R5: An event while status[31] is set and the interrupt flag (status[30]) is clear sets status[30]. `irq` is high exactly when status[30] and interrupt enable (control[26]) are both set.
- R6: An event while status[31] and status[30] are both set does the following, depending on the reset-control field (control[29:28]):
  - If the field is nonzero, `rst_req` goes high for exactly one cycle and the last-reset field (status[29:28]) is loaded with the reset-control value.
  - If the field is 00, nothing happens.
- R7: A status write clears each of status[31], status[30] and status[29:28] where the written bit is 1, and leaves it unchanged where the written bit is 0. Writing 0xC000_0000 is the service operation.
- R8: Once control[29:28] is nonzero, control writes leave it unchanged. The period and interrupt-enable fields still take the written values.
- R9: A service write in the same cycle as an event is applied first, and the event then escalates from the cleared state. The result is status[31]=1, status[30]=0 and no reset request.
- R10: A change of the period field never counts as an event by itself, even when the newly selected bit is already 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the timebase this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = status register |
| wr_data | input | 32 | Write data |
| ctrl_rd | output | 32 | Control register contents |
| stat_rd | output | 32 | Status register contents |
| tb_value | output | 64 | Current timebase value |
| irq | output | 1 | Watchdog interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A service write and a timeout event can fall in the same cycle. The result then depends on which of the two is ordered first inside the status update.

The bench provokes this collision as follows:
- It arms both flags with a nonzero reset-control value.
- It pulses `tick_en` so that the watched bit rises.
- In the very next cycle, which is the cycle in which the event is resolved, it drives the service write.

The outcome is judged at the ports. No reset request may appear, and the status register must read only the next-armed flag set. Losing the event, or letting it escalate to reset, would each give a different status value.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;

   localparam int REG_W   = 32;
   localparam int PSEL_W  = 6;
   localparam int RC_W    = 2;
   localparam int NPERIOD = 1 << PSEL_W;

   // control register layout
   localparam int C_PLO_MSB = 31;
   localparam int C_PLO_LSB = 30;
   localparam int C_PHI_MSB = 20;
   localparam int C_PHI_LSB = 17;
   localparam int C_IE_BIT  = 26;
   localparam int C_RC_MSB  = 29;
   localparam int C_RC_LSB  = 28;

   // status register layout
   localparam int S_ARM_BIT = 31;
   localparam int S_INT_BIT = 30;
   localparam int S_LR_MSB  = 29;
   localparam int S_LR_LSB  = 28;

   typedef enum logic [0:0] {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic [PSEL_W-1:0] psel;
      logic              ie;
      logic [RC_W-1:0]   rc;
   } ctrl_t;

   typedef struct packed {
      logic            armed;
      logic            intr;
      logic [RC_W-1:0] last_rc;
   } stat_t;

endpackage

// File: rtl/esc_wdog_tbase.sv
module esc_wdog_tbase #(
   parameter int TB_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_en,
   output logic [TB_W-1:0] tb_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)       tb_q <= '0;
      else if (tick_en) tb_q <= tb_q + TB_W'(1);
   end

endmodule

// File: rtl/esc_wdog_tap.sv
module esc_wdog_tap
   import esc_wdog_pkg::*;
#(
   parameter int TB_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TB_W-1:0]   tb_q,
   input  logic [PSEL_W-1:0] psel,
   output logic              evt
);

   logic [NPERIOD-1:0] tap_vec;
   logic               tap_now;
   logic               tap_prev;
   logic [PSEL_W-1:0]  psel_prev;

   // period p watches bit TB_W-1-p; periods past the counter width never fire
   for (genvar gi = 0; gi < NPERIOD; gi++) begin : g_tap
      if (TB_W - 1 - gi >= 0) begin : g_live
         assign tap_vec[gi] = tb_q[TB_W-1-gi];
      end else begin : g_dead
         assign tap_vec[gi] = 1'b0;
      end
   end

   assign tap_now = tap_vec[psel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tap_prev  <= 1'b0;
         psel_prev <= '0;
      end else begin
         tap_prev  <= tap_now;
         psel_prev <= psel;
      end
   end

   // a freshly selected bit is only sampled, never counted
   assign evt = tap_now && !tap_prev && (psel == psel_prev);

endmodule

// File: rtl/esc_wdog_regs.sv
module esc_wdog_regs
   import esc_wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             evt,
   output ctrl_t            ctrl_q,
   output stat_t            stat_q,
   output logic             irq,
   output logic             rst_req
);

   ctrl_t ctrl_d;
   stat_t stat_clr;
   stat_t stat_d;
   logic  fire;
   logic  wr_ctrl;
   logic  wr_stat;

   assign wr_ctrl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
   assign wr_stat = wr_en && (reg_sel_e'(wr_sel) == SEL_STAT);

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_ctrl) begin
         ctrl_d.psel = {wr_data[C_PHI_MSB:C_PHI_LSB], wr_data[C_PLO_MSB:C_PLO_LSB]};
         ctrl_d.ie   = wr_data[C_IE_BIT];
         if (ctrl_q.rc == '0) ctrl_d.rc = wr_data[C_RC_MSB:C_RC_LSB];
      end
   end

   // clears first, then the event escalates from the cleared state
   always_comb begin
      stat_clr = stat_q;
      if (wr_stat) begin
         if (wr_data[S_ARM_BIT]) stat_clr.armed = 1'b0;
         if (wr_data[S_INT_BIT]) stat_clr.intr  = 1'b0;
         stat_clr.last_rc = stat_q.last_rc & ~wr_data[S_LR_MSB:S_LR_LSB];
      end
      stat_d = stat_clr;
      fire   = 1'b0;
      if (evt) begin
         if (!stat_clr.armed)      stat_d.armed = 1'b1;
         else if (!stat_clr.intr)  stat_d.intr  = 1'b1;
         else if (ctrl_q.rc != '0) begin
            fire           = 1'b1;
            stat_d.last_rc = ctrl_q.rc;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         stat_q  <= '0;
         rst_req <= 1'b0;
      end else begin
         ctrl_q  <= ctrl_d;
         stat_q  <= stat_d;
         rst_req <= fire;
      end
   end

   assign irq = stat_q.intr && ctrl_q.ie;

endmodule

// File: rtl/esc_wdog.sv
module esc_wdog
   import esc_wdog_pkg::*;
#(
   parameter int TB_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] ctrl_rd,
   output logic [REG_W-1:0] stat_rd,
   output logic [TB_W-1:0]  tb_value,
   output logic             irq,
   output logic             rst_req
);

   if (TB_W < 2 || TB_W > NPERIOD) begin : g_bad_tbw
      $error("esc_wdog: TB_W must lie between 2 and %0d", NPERIOD);
   end
   if (REG_W != 32) begin : g_bad_regw
      $error("esc_wdog: register layout assumes 32-bit registers");
   end

   logic  evt;
   ctrl_t ctrl_q;
   stat_t stat_q;

   esc_wdog_tbase #(.TB_W(TB_W)) tbase_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .tb_q    (tb_value)
   );

   esc_wdog_tap #(.TB_W(TB_W)) tap_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tb_q  (tb_value),
      .psel  (ctrl_q.psel),
      .evt   (evt)
   );

   esc_wdog_regs regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .evt     (evt),
      .ctrl_q  (ctrl_q),
      .stat_q  (stat_q),
      .irq     (irq),
      .rst_req (rst_req)
   );

   always_comb begin
      ctrl_rd                      = '0;
      ctrl_rd[C_PLO_MSB:C_PLO_LSB] = ctrl_q.psel[1:0];
      ctrl_rd[C_PHI_MSB:C_PHI_LSB] = ctrl_q.psel[PSEL_W-1:2];
      ctrl_rd[C_IE_BIT]            = ctrl_q.ie;
      ctrl_rd[C_RC_MSB:C_RC_LSB]   = ctrl_q.rc;
      stat_rd                      = '0;
      stat_rd[S_ARM_BIT]           = stat_q.armed;
      stat_rd[S_INT_BIT]           = stat_q.intr;
      stat_rd[S_LR_MSB:S_LR_LSB]   = stat_q.last_rc;
   end

endmodule

// File: rtl/esc_wdog_chk.sv
module esc_wdog_chk #(
   parameter int TB_W = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick_en,
   input logic [31:0]     ctrl_rd,
   input logic [31:0]     stat_rd,
   input logic [TB_W-1:0] tb_value,
   input logic            irq,
   input logic            rst_req
);

   p_tb_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> tb_value == $past(tb_value) + TB_W'($past(tick_en)))
      else $error("timebase step broken");

   p_intr_after_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(stat_rd[30])) |-> $past(stat_rd[31]))
      else $error("interrupt flag set without prior arm");

   p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctrl_rd[26] && stat_rd[30]))
      else $error("irq without enable and flag");

   p_rst_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req)
      else $error("reset request longer than one cycle");

   p_rst_from_stage3_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(rst_req)) |-> $past(stat_rd[31] && stat_rd[30]))
      else $error("reset request before third stage");

   p_last_rc_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (stat_rd[29:28] == ctrl_rd[29:28] && ctrl_rd[29:28] != 2'b00))
      else $error("last-reset field mismatch");

   p_rc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctrl_rd[29:28]) != 2'b00) |-> $stable(ctrl_rd[29:28]))
      else $error("reset-control field changed after being set");

endmodule

bind esc_wdog esc_wdog_chk #(.TB_W(TB_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .ctrl_rd  (ctrl_rd),
   .stat_rd  (stat_rd),
   .tb_value (tb_value),
   .irq      (irq),
   .rst_req  (rst_req)
);

// File: tb/esc_wdog_tb_top.sv
module esc_wdog_tb_top;

   localparam int TB_W = 64;
   localparam logic [31:0] PING = 32'hC000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] ctrl_rd;
   logic [31:0] stat_rd;
   logic [TB_W-1:0] tb_value;
   logic        irq;
   logic        rst_req;

   int checks = 0;
   int failures = 0;
   int rst_seen = 0;
   longint unsigned tb_model = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   esc_wdog #(.TB_W(TB_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
      .stat_rd(stat_rd), .tb_value(tb_value), .irq(irq), .rst_req(rst_req)
   );

   function automatic logic [31:0] mk_ctrl(input logic [5:0] p, input logic ie,
                                           input logic [1:0] rc);
      logic [31:0] d;
      d        = '0;
      d[31:30] = p[1:0];
      d[20:17] = p[5:2];
      d[26]    = ie;
      d[29:28] = rc;
      return d;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic step();
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      tb_model++;
      @(negedge clk);
      if (rst_req) rst_seen++;
      @(negedge clk);
      if (rst_req) rst_seen++;
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 tb", tb_value, 0);
      chk("R1 ctrl", ctrl_rd, 0);
      chk("R1 stat", stat_rd, 0);
      chk("R1 irq", irq, 0);
      chk("R1 rst_req", rst_req, 0);
   endtask

   task automatic t_timebase();
      for (int i = 0; i < 5; i++) step();
      chk("R2 count", tb_value, tb_model);
      repeat (3) @(negedge clk);
      chk("R2 hold", tb_value, tb_model);
      chk("R3 period0 no event", stat_rd, 0);
   endtask

   task automatic t_period_change();
      wr(1'b0, mk_ctrl(6'd63, 1'b1, 2'b00));
      repeat (2) @(negedge clk);
      chk("R3 ctrl layout", ctrl_rd, mk_ctrl(6'd63, 1'b1, 2'b00));
      chk("R10 no event on period change", stat_rd, 0);
   endtask

   task automatic t_escalate();
      rst_seen = 0;
      step();
      chk("R3 even tick no event", stat_rd, 0);
      step();
      chk("R4 first event arms", stat_rd, 32'h8000_0000);
      chk("R4 no irq yet", irq, 0);
      step(); step();
      chk("R5 second event", stat_rd, 32'hC000_0000);
      chk("R5 irq", irq, 1);
      step(); step();
      chk("R6 rc=0 no reset", rst_seen, 0);
      chk("R6 rc=0 stat", stat_rd, 32'hC000_0000);
   endtask

   task automatic t_ping();
      wr(1'b1, PING);
      chk("R7 ping clears", stat_rd, 0);
      chk("R7 irq low", irq, 0);
      step(); step();
      chk("R7 armed", stat_rd, 32'h8000_0000);
      wr(1'b1, PING);
      step(); step();
      chk("R7 ping prevents interrupt", stat_rd, 32'h8000_0000);
      chk("R7 ping irq", irq, 0);
      wr(1'b1, 32'h0000_0000);
      chk("R7 zero write no effect", stat_rd, 32'h8000_0000);
      wr(1'b1, 32'h4000_0000);
      chk("R7 selective clear", stat_rd, 32'h8000_0000);
   endtask

   task automatic t_ie_mask();
      wr(1'b0, mk_ctrl(6'd63, 1'b0, 2'b00));
      wr(1'b1, PING);
      step(); step();
      step(); step();
      chk("R5 flag set ie off", stat_rd, 32'hC000_0000);
      chk("R5 irq masked", irq, 0);
      wr(1'b0, mk_ctrl(6'd63, 1'b1, 2'b00));
      chk("R5 irq unmasked", irq, 1);
   endtask

   task automatic t_reset_fire();
      wr(1'b0, mk_ctrl(6'd63, 1'b1, 2'b10));
      wr(1'b1, PING);
      rst_seen = 0;
      step(); step();
      step(); step();
      chk("R6 no reset before stage3", rst_seen, 0);
      step(); step();
      chk("R6 one reset pulse", rst_seen, 1);
      chk("R6 last rc recorded", stat_rd, 32'hE000_0000);
      wr(1'b0, mk_ctrl(6'd62, 1'b0, 2'b01));
      chk("R8 rc sticky others written", ctrl_rd, mk_ctrl(6'd62, 1'b0, 2'b10));
      wr(1'b0, mk_ctrl(6'd63, 1'b1, 2'b00));
      chk("R8 rc survives zero write", ctrl_rd, mk_ctrl(6'd63, 1'b1, 2'b10));
      wr(1'b1, 32'h3000_0000);
      chk("R7 last rc clear", stat_rd, 32'hC000_0000);
      step(); step();
      chk("R6 fires again", rst_seen, 2);
      chk("R6 last rc again", stat_rd, 32'hE000_0000);
   endtask

   task automatic t_collide();
      wr(1'b1, 32'h3000_0000);
      rst_seen = 0;
      step();
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      tb_model++;
      wr_en = 1'b1; wr_sel = 1'b1; wr_data = PING;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      if (rst_req) rst_seen++;
      @(negedge clk);
      if (rst_req) rst_seen++;
      chk("R9 collide no reset", rst_seen, 0);
      chk("R9 collide stat", stat_rd, 32'h8000_0000);
   endtask

   task automatic t_p62();
      wr(1'b1, PING);
      wr(1'b0, mk_ctrl(6'd62, 1'b1, 2'b10));
      step();
      chk("R3 bit1 rise arms", stat_rd, 32'h8000_0000);
      step();
      chk("R3 bit1 high no event", stat_rd, 32'h8000_0000);
      step(); step(); step();
      chk("R3 bit1 second rise", stat_rd, 32'hC000_0000);
      chk("R5 irq p62", irq, 1);
   endtask

   task automatic t_disable();
      wr(1'b0, mk_ctrl(6'd0, 1'b0, 2'b00));
      chk("R8 disable keeps rc", ctrl_rd, mk_ctrl(6'd0, 1'b0, 2'b10));
      wr(1'b1, PING);
      rst_seen = 0;
      for (int i = 0; i < 4; i++) step();
      chk("R3 period0 quiet", stat_rd, 0);
      chk("R3 period0 no reset", rst_seen, 0);
      chk("R2 final count", tb_value, tb_model);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog timeout actual=hung expected=done");
         report();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_timebase();
      t_period_change();
      t_escalate();
      t_ping();
      t_ie_mask();
      t_reset_fire();
      t_collide();
      t_p62();
      t_disable();
      done = 1'b1;
      report();
   end

endmodule